// File: doc/BRIEF.md
# Resize ratio coefficient calculator

This block turns a requested image scaling along two axes into the control word that a scaling datapath consumes. For each axis it receives the source size and the destination size. It first checks the request against the supported range. It then picks a pre-decimation factor of 1, 2 or 4 by halving the source size. Finally it computes a fixed-point step: 2^13 times (working size − 1), divided by (destination size − 1). The division runs in a restoring divider that produces one quotient bit per clock.

A single `start` pulse launches the vertical and horizontal calculations together. When both have finished, `done` pulses for one cycle. At that point `rsc_word` holds both results packed into one 32-bit word, and the per-axis `err` and `warn` flags are valid. The outputs hold their values until the next accepted request.

Top module: `rsz_coef_pair`

## Requirements
- R1: An axis whose source size exceeds 4096 or whose destination size exceeds 1024 is rejected. Its `err` bit is set and its code and coefficient fields read zero. A source of exactly 4096 with a destination of exactly 1024 is accepted.
- R2: An axis is rejected when four times the destination size is less than the source size. A ratio of exactly 4:1 is accepted.
- R3: An axis with a destination size below 2 or a source size of 0 is rejected, so the divider never sees a zero divisor.
- R4: The downsize code is the number of halvings applied to the source size. Halving repeats while the working size is above 1024 or at least twice the destination size, and stops after at most 2 halvings. The code is therefore 0, 1 or 2, and never 3.
- R5: For an accepted axis, the coefficient equals floor(8192 × (working size − 1) / (destination size − 1)), where the working size is the source size after the halvings of R4.
- R6: When the quotient of R5 is 16384 or more, the coefficient reads 0x3FFF and that axis's `warn` bit is set. Otherwise `warn` is clear. `warn` is never set together with `err` on the same axis.
- R7: `rsc_word` carries the vertical code in bits 31:30, the vertical coefficient in bits 29:16, the horizontal code in bits 15:14 and the horizontal coefficient in bits 13:0. Bit 0 of `err` and `warn` is the horizontal axis, and bit 1 is the vertical axis.
- R8: `start` is accepted only while `busy` is low. An accepted start raises `busy` on the next cycle. A start seen while busy has no effect on the result or on the number of `done` pulses. Each accepted request produces exactly one single-cycle `done` pulse, with `busy` low in that cycle.
- R9: While reset is asserted, and until the first request completes, `busy`, `done`, `rsc_word`, `err` and `warn` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| start | input | 1 | Request pulse; sampled only while idle |
| in_width | input | 13 | Horizontal source size |
| in_height | input | 13 | Vertical source size |
| out_width | input | 13 | Horizontal destination size |
| out_height | input | 13 | Vertical destination size |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when both axes have finished |
| rsc_word | output | 32 | Packed codes and coefficients of both axes |
| err | output | 2 | Per-axis unsupported-request flag (bit 1 vertical, bit 0 horizontal) |
| warn | output | 2 | Per-axis coefficient saturation flag (bit 1 vertical, bit 0 horizontal) |

## Verification
The bench aims at the exact edges of the range checks: 4096 versus 4097, 1024 versus 1025, exactly 4:1 versus just past it, and destination sizes of 0 and 1. An off-by-one comparison would flip `err` on one of these. Small requests such as 3→2 and 7→2 push the quotient to exactly 16384; a design that clamps with a strict greater-than would emit 0x0000 or a wrapped value instead of 0x3FFF. The source sizes 1025 and 4096 separate the "above 1024" halving rule from the "twice the destination" rule, and a cap on the halving count that is off by one shows up as code 3. A second start issued mid-calculation with different sizes exposes a design that restarts or double-pulses `done`.

// File: rtl/rsz_pkg.sv
package rsz_pkg;

  // Default geometry of the calculator
  localparam int RSZ_SIZE_W    = 13;   // bits for one size value
  localparam int RSZ_COEF_W    = 14;   // coefficient field width
  localparam int RSZ_CODE_W    = 2;    // downsize code width
  localparam int RSZ_FRAC_BITS = 13;   // fixed-point scale 2^13
  localparam int RSZ_MAX_IN    = 4096; // largest accepted source size
  localparam int RSZ_MAX_OUT   = 1024; // largest accepted destination size
  localparam int RSZ_MAX_DECIM = 2;    // most halvings applied

  typedef enum logic [1:0] {
    AX_IDLE = 2'd0,
    AX_EVAL = 2'd1,
    AX_DIV  = 2'd2
  } ax_state_t;

endpackage

// File: rtl/rsz_rdiv.sv
// Restoring divider, one quotient bit per clock, NUM_W cycles per division.
module rsz_rdiv #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q, acc_n;
  logic [DEN_W-1:0] rem_q, rem_n;
  logic [DEN_W-1:0] den_q, den_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             done_q, done_n;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;

  assign shifted = {rem_q, acc_q[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den_q};
  assign fits    = ~trial[DEN_W+1];

  always_comb begin
    acc_n  = acc_q;
    rem_n  = rem_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (load && !busy_q) begin
      acc_n  = num;
      rem_n  = '0;
      den_n  = den;
      cnt_n  = CNT_W'(NUM_W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      acc_n = {acc_q[NUM_W-2:0], fits};
      rem_n = fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
      cnt_n = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      rem_q  <= rem_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign quo  = acc_q;

endmodule

// File: rtl/rsz_prescale.sv
// Range check and pre-decimation chain for one axis (combinational).
module rsz_prescale #(
  parameter int SIZE_W    = rsz_pkg::RSZ_SIZE_W,
  parameter int CODE_W    = rsz_pkg::RSZ_CODE_W,
  parameter int MAX_IN    = rsz_pkg::RSZ_MAX_IN,
  parameter int MAX_OUT   = rsz_pkg::RSZ_MAX_OUT,
  parameter int MAX_DECIM = rsz_pkg::RSZ_MAX_DECIM
) (
  input  logic [SIZE_W-1:0] in_size,
  input  logic [SIZE_W-1:0] out_size,
  output logic              reject,
  output logic [CODE_W-1:0] code,
  output logic [SIZE_W-1:0] work_size
);

  localparam int EXT_W = SIZE_W + 2;

  logic [EXT_W-1:0] in_ext, out_ext, out_x2, out_x4;
  logic             in_big, out_big, in_zero, out_small, ratio_bad;

  assign in_ext    = EXT_W'(in_size);
  assign out_ext   = EXT_W'(out_size);
  assign out_x2    = out_ext << 1;
  assign out_x4    = out_ext << 2;
  assign in_big    = in_ext > EXT_W'(MAX_IN);
  assign out_big   = out_ext > EXT_W'(MAX_OUT);
  assign in_zero   = in_size == '0;
  assign out_small = out_ext < EXT_W'(2);
  assign ratio_bad = out_x4 < in_ext;
  assign reject    = in_big | out_big | in_zero | out_small | ratio_bad;

  logic [SIZE_W-1:0] ws [MAX_DECIM+1];
  logic [CODE_W-1:0] cd [MAX_DECIM+1];

  assign ws[0] = in_size;
  assign cd[0] = '0;

  // One stage per permitted halving; once a stage declines, the size is
  // unchanged and every later stage declines too.
  for (genvar k = 0; k < MAX_DECIM; k++) begin : g_stage
    logic halve;
    assign halve     = (EXT_W'(ws[k]) > EXT_W'(MAX_OUT)) || (EXT_W'(ws[k]) >= out_x2);
    assign ws[k+1]   = halve ? (ws[k] >> 1) : ws[k];
    assign cd[k+1]   = cd[k] + CODE_W'(halve);
  end

  assign work_size = ws[MAX_DECIM];
  assign code      = cd[MAX_DECIM];

endmodule

// File: rtl/rsz_axis.sv
// Sequential coefficient calculation for one axis.
module rsz_axis
  import rsz_pkg::*;
#(
  parameter int SIZE_W    = RSZ_SIZE_W,
  parameter int COEF_W    = RSZ_COEF_W,
  parameter int CODE_W    = RSZ_CODE_W,
  parameter int FRAC_BITS = RSZ_FRAC_BITS,
  parameter int MAX_IN    = RSZ_MAX_IN,
  parameter int MAX_OUT   = RSZ_MAX_OUT,
  parameter int MAX_DECIM = RSZ_MAX_DECIM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [SIZE_W-1:0] out_size,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic [COEF_W-1:0] coef,
  output logic              err,
  output logic              warn
);

  localparam int NUM_W = SIZE_W + FRAC_BITS;

  ax_state_t         st_q, st_n;
  logic [SIZE_W-1:0] in_q, in_n, out_q, out_n;
  logic [CODE_W-1:0] pend_q, pend_n, code_q, code_n;
  logic [COEF_W-1:0] coef_q, coef_n;
  logic              err_q, err_n, warn_q, warn_n, done_q, done_n;

  logic              reject;
  logic [CODE_W-1:0] pre_code;
  logic [SIZE_W-1:0] work_size, ws_m1, den;
  logic [NUM_W-1:0]  div_num, div_quo;
  logic              div_load, div_done, ovf;

  rsz_prescale #(
    .SIZE_W(SIZE_W), .CODE_W(CODE_W), .MAX_IN(MAX_IN),
    .MAX_OUT(MAX_OUT), .MAX_DECIM(MAX_DECIM)
  ) u_pre (
    .in_size  (in_q),
    .out_size (out_q),
    .reject   (reject),
    .code     (pre_code),
    .work_size(work_size)
  );

  assign ws_m1    = work_size - SIZE_W'(1);
  assign den      = out_q - SIZE_W'(1);
  assign div_num  = {ws_m1, {FRAC_BITS{1'b0}}};
  assign div_load = (st_q == AX_EVAL) && !reject;

  rsz_rdiv #(.NUM_W(NUM_W), .DEN_W(SIZE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (div_load),
    .num  (div_num),
    .den  (den),
    .done (div_done),
    .quo  (div_quo)
  );

  assign ovf = |div_quo[NUM_W-1:COEF_W];

  always_comb begin
    st_n   = st_q;
    in_n   = in_q;
    out_n  = out_q;
    pend_n = pend_q;
    code_n = code_q;
    coef_n = coef_q;
    err_n  = err_q;
    warn_n = warn_q;
    done_n = 1'b0;
    unique case (st_q)
      AX_IDLE: begin
        if (start) begin
          in_n  = in_size;
          out_n = out_size;
          st_n  = AX_EVAL;
        end
      end
      AX_EVAL: begin
        if (reject) begin
          code_n = '0;
          coef_n = '0;
          err_n  = 1'b1;
          warn_n = 1'b0;
          done_n = 1'b1;
          st_n   = AX_IDLE;
        end else begin
          pend_n = pre_code;
          st_n   = AX_DIV;
        end
      end
      AX_DIV: begin
        if (div_done) begin
          code_n = pend_q;
          coef_n = ovf ? '1 : div_quo[COEF_W-1:0];
          warn_n = ovf;
          err_n  = 1'b0;
          done_n = 1'b1;
          st_n   = AX_IDLE;
        end
      end
      default: st_n = AX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AX_IDLE;
      in_q   <= '0;
      out_q  <= '0;
      pend_q <= '0;
      code_q <= '0;
      coef_q <= '0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      in_q   <= in_n;
      out_q  <= out_n;
      pend_q <= pend_n;
      code_q <= code_n;
      coef_q <= coef_n;
      err_q  <= err_n;
      warn_q <= warn_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign code = code_q;
  assign coef = coef_q;
  assign err  = err_q;
  assign warn = warn_q;

endmodule

// File: rtl/rsz_coef_pair.sv
// Two-axis resize coefficient calculator with a packed result word.
module rsz_coef_pair #(
  parameter int SIZE_W    = rsz_pkg::RSZ_SIZE_W,
  parameter int COEF_W    = rsz_pkg::RSZ_COEF_W,
  parameter int CODE_W    = rsz_pkg::RSZ_CODE_W,
  parameter int FRAC_BITS = rsz_pkg::RSZ_FRAC_BITS,
  parameter int MAX_IN    = rsz_pkg::RSZ_MAX_IN,
  parameter int MAX_OUT   = rsz_pkg::RSZ_MAX_OUT,
  parameter int MAX_DECIM = rsz_pkg::RSZ_MAX_DECIM
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [SIZE_W-1:0]              in_width,
  input  logic [SIZE_W-1:0]              in_height,
  input  logic [SIZE_W-1:0]              out_width,
  input  logic [SIZE_W-1:0]              out_height,
  output logic                           busy,
  output logic                           done,
  output logic [2*(CODE_W+COEF_W)-1:0]   rsc_word,
  output logic [1:0]                     err,
  output logic [1:0]                     warn
);

  localparam int N_AX = 2;               // index 0 horizontal, 1 vertical
  localparam int AX_W = CODE_W + COEF_W;

  logic [SIZE_W-1:0] ax_in  [N_AX];
  logic [SIZE_W-1:0] ax_out [N_AX];
  logic [CODE_W-1:0] ax_code[N_AX];
  logic [COEF_W-1:0] ax_coef[N_AX];
  logic [N_AX-1:0]   ax_done, ax_err, ax_warn;
  logic              ax_start;

  assign ax_in[0]  = in_width;
  assign ax_in[1]  = in_height;
  assign ax_out[0] = out_width;
  assign ax_out[1] = out_height;

  logic            run_q, run_n, done_q, done_n;
  logic [N_AX-1:0] got_q, got_n;

  assign ax_start = start && !run_q;

  for (genvar g = 0; g < N_AX; g++) begin : g_axis
    rsz_axis #(
      .SIZE_W(SIZE_W), .COEF_W(COEF_W), .CODE_W(CODE_W), .FRAC_BITS(FRAC_BITS),
      .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT), .MAX_DECIM(MAX_DECIM)
    ) u_axis (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (ax_start),
      .in_size (ax_in[g]),
      .out_size(ax_out[g]),
      .done    (ax_done[g]),
      .code    (ax_code[g]),
      .coef    (ax_coef[g]),
      .err     (ax_err[g]),
      .warn    (ax_warn[g])
    );
    assign rsc_word[g*AX_W +: AX_W] = {ax_code[g], ax_coef[g]};
  end

  // Join the two axes: done fires once both have reported.
  always_comb begin
    run_n  = run_q;
    got_n  = got_q;
    done_n = 1'b0;
    if (ax_start) begin
      run_n = 1'b1;
      got_n = '0;
    end else if (run_q) begin
      got_n = got_q | ax_done;
      if (&got_n) begin
        run_n  = 1'b0;
        done_n = 1'b1;
        got_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      got_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      got_q  <= got_n;
      done_q <= done_n;
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign err  = ax_err;
  assign warn = ax_warn;

endmodule

// File: rtl/rsz_coef_pair_chk.sv
module rsz_coef_pair_chk #(
  parameter int CODE_W    = 2,
  parameter int COEF_W    = 14,
  parameter int MAX_DECIM = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         busy,
  input logic                         done,
  input logic [2*(CODE_W+COEF_W)-1:0] rsc_word,
  input logic [1:0]                   err,
  input logic [1:0]                   warn
);

  localparam int AX_W = CODE_W + COEF_W;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  h_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err[0] |-> (rsc_word[AX_W-1:0] == '0));

  // R1
  v_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err[1] |-> (rsc_word[2*AX_W-1:AX_W] == '0));

  // R6
  h_warn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn[0] |-> ((rsc_word[COEF_W-1:0] == '1) && !err[0]));

  // R6
  v_warn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn[1] |-> ((rsc_word[AX_W+COEF_W-1:AX_W] == '1) && !err[1]));

  // R4
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsc_word[AX_W-1 -: CODE_W] <= CODE_W'(MAX_DECIM)) &&
    (rsc_word[2*AX_W-1 -: CODE_W] <= CODE_W'(MAX_DECIM)));

endmodule

bind rsz_coef_pair rsz_coef_pair_chk #(
  .CODE_W(CODE_W), .COEF_W(COEF_W), .MAX_DECIM(MAX_DECIM)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .rsc_word(rsc_word),
  .err     (err),
  .warn    (warn)
);

// File: tb/rsz_coef_pair_bench.sv
module rsz_coef_pair_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [12:0] in_width = '0, in_height = '0, out_width = '0, out_height = '0;
  logic        busy, done;
  logic [31:0] rsc_word;
  logic [1:0]  err, warn;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rsz_coef_pair u_rsz_coef_pair (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_width(in_width), .in_height(in_height),
    .out_width(out_width), .out_height(out_height),
    .busy(busy), .done(done), .rsc_word(rsc_word), .err(err), .warn(warn)
  );

  // Stimulus: {in_h, out_h, in_w, out_w}
  localparam int NV = 12;
  localparam logic [51:0] VECS [NV] = '{
    {13'd480,  13'd480,  13'd640,  13'd640},
    {13'd1080, 13'd720,  13'd1920, 13'd1024},
    {13'd100,  13'd400,  13'd200,  13'd800},
    {13'd5000, 13'd1000, 13'd640,  13'd480},
    {13'd640,  13'd1025, 13'd320,  13'd240},
    {13'd4097, 13'd1024, 13'd4096, 13'd1024},
    {13'd401,  13'd100,  13'd400,  13'd100},
    {13'd3,    13'd2,    13'd7,    13'd2},
    {13'd2,    13'd1,    13'd0,    13'd0},
    {13'd0,    13'd2,    13'd10,   13'd3},
    {13'd2,    13'd2,    13'd1024, 13'd1024},
    {13'd1025, 13'd1024, 13'd1,    13'd2}
  };

  // Expected result of one axis, from the requirement text.
  function automatic void ref_axis(input int in_s, input int out_s,
                                   output logic [1:0] c, output logic [13:0] k,
                                   output logic e, output logic w);
    int ws, n;
    longint q;
    e = (in_s > 4096) || (out_s > 1024) || (out_s < 2) || (in_s < 1) || (out_s * 4 < in_s);
    c = 2'd0; k = 14'd0; w = 1'b0;
    if (!e) begin
      ws = in_s; n = 0;
      while (((ws > 1024) || (ws >= 2 * out_s)) && (n < 2)) begin
        ws = ws / 2;
        n++;
      end
      q = (longint'(8192) * longint'(ws - 1)) / longint'(out_s - 1);
      c = 2'(n);
      if (q >= 16384) begin k = 14'h3FFF; w = 1'b1; end
      else k = 14'(q);
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] s_word;
  logic [1:0]  s_err, s_warn;

  task automatic run_req(input logic [12:0] ih, input logic [12:0] oh,
                         input logic [12:0] iw, input logic [12:0] ow);
    int k;
    in_height = ih; out_height = oh; in_width = iw; out_width = ow;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", {31'd0, busy}, 32'd1);
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R8 done seen", {31'd0, done}, 32'd1);
    s_word = rsc_word; s_err = err; s_warn = warn;
    chk("R8 busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    logic [1:0]  vc, hc;
    logic [13:0] vk, hk;
    logic        ve, he, vw, hw;
    int          pulses;
    logic [31:0] cap;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 word", rsc_word, 32'd0);
    chk("R9 flags", {28'd0, err, warn}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 after release", {rsc_word[31:4], busy, done, err | warn}, 32'd0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      ref_axis(int'(VECS[i][51:39]), int'(VECS[i][38:26]), vc, vk, ve, vw);
      ref_axis(int'(VECS[i][25:13]), int'(VECS[i][12:0]),  hc, hk, he, hw);
      run_req(VECS[i][51:39], VECS[i][38:26], VECS[i][25:13], VECS[i][12:0]);
      chk("R4 R5 R7 word", s_word, {vc, vk, hc, hk});
      chk("R1 R2 R3 err", {30'd0, s_err}, {30'd0, ve, he});
      chk("R6 warn", {30'd0, s_warn}, {30'd0, vw, hw});
    end

    // R7: field positions with literal values (480/480 vertical, 3/2 horizontal)
    run_req(13'd480, 13'd480, 13'd3, 13'd2);
    chk("R7 packed literal", s_word, 32'h2000_3FFF);
    chk("R6 horizontal warn only", {30'd0, s_warn}, 32'd1);

    // R4: code 1 from the above-1024 rule, code 2 at the upper limits (R1 boundary)
    run_req(13'd1025, 13'd1024, 13'd4096, 13'd1024);
    chk("R4 R1 limits literal", s_word, 32'h4FFB_A000);
    chk("R1 limits accepted", {30'd0, s_err}, 32'd0);

    // R2: rejected vertical, accepted horizontal, zeroed field
    run_req(13'd401, 13'd100, 13'd640, 13'd320);
    chk("R2 reject literal", s_word, 32'h0000_6000);
    chk("R2 err vertical", {30'd0, s_err}, 32'd2);

    // R8: start while busy is ignored
    in_height = 13'd640; out_height = 13'd640; in_width = 13'd640; out_width = 13'd640;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    in_height = 13'd3; out_height = 13'd2; in_width = 13'd3; out_width = 13'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pulses = 0; cap = '0;
    for (int t = 0; t < 80; t++) begin
      if (done) begin pulses++; cap = rsc_word; end
      @(negedge clk);
    end
    chk("R8 single done", pulses, 32'd1);
    chk("R8 ignored start result", cap, 32'h2000_2000);
    chk("R8 ignored start warn", {30'd0, warn}, 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule